// File: doc/BRIEF.md
# Up/Down BCD Hour Counter

This block keeps the hour of a day as two packed BCD digits, tens and units, and steps through 24 states on each enabled clock edge. A direction input picks counting up or down. Each digit has its own modulo-10 counter. Control logic chains the two digits and cuts the count short at the day boundary in both directions. The result is a clean ring 00, 01, ..., 23, 00, and the reverse.

The stored count always runs on a 24-hour basis. A mode input picks only how that count appears at the outputs. One choice is the plain 24-hour BCD value. The other is a 12-hour BCD value with a flag that is high in the afternoon. A terminal-count output marks the enabled step that crosses the day boundary, so that a day or date counter can be chained after this block. The outputs are raw BCD; display decoding is done elsewhere.

Top module: `hour_ring_bcd`

## Requirements
- R1: While rst_i is high at a rising clock edge, the stored hour becomes 00, whatever the other inputs are. Reset is synchronous and wins over en_i.
- R2: With en_i low and rst_i low, the stored hour holds its value across clock edges.
- R3: With en_i high and down_i low, the hour goes up by one per edge. When the units digit is 9, it goes to 0 and the tens digit goes up by one.
- R4: With en_i high and down_i low, hour 23 goes to 00: both digits clear on the same edge.
- R5: With en_i high and down_i high, the hour goes down by one per edge. When the units digit is 0, it goes to 9 and the tens digit goes down by one.
- R6: With en_i high and down_i high, hour 00 goes to 23.
- R7: tc_o is combinational and high exactly when rst_i is low, en_i is high, and either down_i is low with the hour at 23, or down_i is high with the hour at 00. Otherwise it is low.
- R8: With mode12_i low, tens_o and units_o carry the stored hour in BCD (tens in tens_o, units in units_o), and pm_o is 0.
- R9: With mode12_i high, the hour appears as a 12-hour value with pm_o as follows:
  - hour 0 shows as 12 with pm_o = 0;
  - hours 1 to 11 show unchanged with pm_o = 0;
  - hour 12 shows as 12 with pm_o = 1;
  - hours 13 to 23 show as the hour minus 12 with pm_o = 1.
- R10: mode12_i changes only the outputs. The count sequence and the stored hour do not depend on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Count enable |
| down_i | input | 1 | Direction: 0 counts up, 1 counts down |
| mode12_i | input | 1 | Output code: 0 gives 24-hour, 1 gives 12-hour with flag |
| tens_o | output | 4 | Tens BCD digit of the shown hour |
| units_o | output | 4 | Units BCD digit of the shown hour |
| pm_o | output | 1 | Afternoon flag in 12-hour code, 0 in 24-hour code |
| tc_o | output | 1 | Terminal-count pulse on the wrapping step |

## Verification
Two functions can act in the same cycle. The terminal-count pulse and the two-digit wrap can meet a mode switch. Reset can meet an enabled step at 23, which would otherwise wrap. The bench turns on 12-hour code in the same cycle that the counter sits at 23 counting up. It then checks the shown 11 with the afternoon flag, the pulse, and a following 12 with the flag clear. It also holds reset high while enable is high at the boundary, and checks that the pulse stays low and that the next value is 00 and not a wrapped one.

// File: rtl/hour_ring_pkg.sv
package hour_ring_pkg;

  localparam int DIGW = 4;

  typedef logic [DIGW-1:0] bcd_t;

  typedef struct packed {
    bcd_t tens;
    bcd_t units;
  } hour_t;

  typedef struct packed {
    hour_t shown;
    logic  pm;
  } shown_t;

  // packed BCD pair to binary
  function automatic logic [6:0] hour_to_bin(hour_t h);
    return 7'({3'b000, h.tens}) * 7'd10 + 7'({3'b000, h.units});
  endfunction

  // binary (0..99) to packed BCD pair
  function automatic hour_t bin_to_hour(logic [6:0] b);
    hour_t r;
    r.tens  = bcd_t'(b / 7'd10);
    r.units = bcd_t'(b % 7'd10);
    return r;
  endfunction

  // 24-hour binary hour to 12-hour shown value plus afternoon flag
  function automatic shown_t to_twelve(hour_t h, logic [6:0] half);
    logic [6:0] b;
    logic [6:0] d;
    shown_t     r;
    b = hour_to_bin(h);
    if (b == 7'd0)     d = half;
    else if (b > half) d = b - half;
    else               d = b;
    r.shown = bin_to_hour(d);
    r.pm    = (b >= half);
    return r;
  endfunction

endpackage

// File: rtl/hour_digit.sv
module hour_digit #(
  parameter int DIGW = 4,
  parameter int MAXV = 9
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            inc_i,
  input  logic            dec_i,
  input  logic            ld_i,
  input  logic [DIGW-1:0] ld_val_i,
  output logic [DIGW-1:0] q_o,
  output logic            at_max_o,
  output logic            at_zero_o
);
  localparam logic [DIGW-1:0] MAXQ = DIGW'(MAXV);

  logic [DIGW-1:0] q_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)      q_q <= '0;
    else if (ld_i)  q_q <= ld_val_i;
    else if (inc_i) q_q <= (q_q == MAXQ) ? '0 : q_q + 1'b1;
    else if (dec_i) q_q <= (q_q == '0) ? MAXQ : q_q - 1'b1;
  end

  assign q_o       = q_q;
  assign at_max_o  = (q_q == MAXQ);
  assign at_zero_o = (q_q == '0);

  AST_DIGIT_IN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    (inc_i || dec_i || ld_i) |=> (q_q <= MAXQ)); // R3

  AST_DIGIT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (!inc_i && !dec_i && !ld_i) |=> $stable(q_q)); // R2
endmodule

// File: rtl/hour_step_ctrl.sv
module hour_step_ctrl #(
  parameter int DIGW   = 4,
  parameter int LAST_T = 2,
  parameter int LAST_U = 3
) (
  input  logic            rst_i,
  input  logic            en_i,
  input  logic            down_i,
  input  logic [DIGW-1:0] tens_i,
  input  logic [DIGW-1:0] units_i,
  input  logic            u_at_max_i,
  input  logic            u_at_zero_i,
  input  logic            t_at_zero_i,
  output logic            u_inc_o,
  output logic            u_dec_o,
  output logic            t_inc_o,
  output logic            t_dec_o,
  output logic            ld_o,
  output logic [DIGW-1:0] ld_t_o,
  output logic [DIGW-1:0] ld_u_o,
  output logic            at_last_o,
  output logic            at_first_o,
  output logic            tc_o
);
  assign at_last_o  = (tens_i == DIGW'(LAST_T)) && (units_i == DIGW'(LAST_U));
  assign at_first_o = t_at_zero_i && u_at_zero_i;

  always_comb begin
    u_inc_o = 1'b0;
    u_dec_o = 1'b0;
    t_inc_o = 1'b0;
    t_dec_o = 1'b0;
    ld_o    = 1'b0;
    ld_t_o  = '0;
    ld_u_o  = '0;
    if (en_i) begin
      if (!down_i) begin
        if (at_last_o) ld_o = 1'b1;
        else begin
          u_inc_o = 1'b1;
          t_inc_o = u_at_max_i;
        end
      end else begin
        if (at_first_o) begin
          ld_o   = 1'b1;
          ld_t_o = DIGW'(LAST_T);
          ld_u_o = DIGW'(LAST_U);
        end else begin
          u_dec_o = 1'b1;
          t_dec_o = u_at_zero_i;
        end
      end
    end
  end

  assign tc_o = !rst_i && en_i && (down_i ? at_first_o : at_last_o);

  always_comb begin
    if (!rst_i) begin
      AST_ONE_ACTION: assert ($countones({u_inc_o, u_dec_o, ld_o}) <= 1); // R3
    end
  end
endmodule

// File: rtl/hour_code_map.sv
module hour_code_map
  import hour_ring_pkg::*;
#(
  parameter int HOURS = 24
) (
  input  logic  mode12_i,
  input  hour_t hour_i,
  output hour_t shown_o,
  output logic  pm_o
);
  localparam logic [6:0] HALF = 7'(HOURS / 2);

  shown_t twelve;

  always_comb begin
    twelve = to_twelve(hour_i, HALF);
    if (mode12_i) begin
      shown_o = twelve.shown;
      pm_o    = twelve.pm;
    end else begin
      shown_o = hour_i;
      pm_o    = 1'b0;
    end
  end
endmodule

// File: rtl/hour_ring_bcd.sv
module hour_ring_bcd
  import hour_ring_pkg::*;
#(
  parameter int HOURS = 24
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            en_i,
  input  logic            down_i,
  input  logic            mode12_i,
  output logic [DIGW-1:0] tens_o,
  output logic [DIGW-1:0] units_o,
  output logic            pm_o,
  output logic            tc_o
);
  localparam int LAST   = HOURS - 1;
  localparam int LAST_T = LAST / 10;
  localparam int LAST_U = LAST % 10;

  logic            u_inc, u_dec, t_inc, t_dec, ld;
  logic [DIGW-1:0] ld_t, ld_u;
  logic            u_at_max, u_at_zero, t_at_max, t_at_zero;
  logic            at_last, at_first;
  hour_t           hour_q;
  hour_t           shown;

  hour_digit #(.DIGW(DIGW), .MAXV(9)) u_units (
    .clk_i(clk_i), .rst_i(rst_i), .inc_i(u_inc), .dec_i(u_dec),
    .ld_i(ld), .ld_val_i(ld_u), .q_o(hour_q.units),
    .at_max_o(u_at_max), .at_zero_o(u_at_zero)
  );

  hour_digit #(.DIGW(DIGW), .MAXV(9)) u_tens (
    .clk_i(clk_i), .rst_i(rst_i), .inc_i(t_inc), .dec_i(t_dec),
    .ld_i(ld), .ld_val_i(ld_t), .q_o(hour_q.tens),
    .at_max_o(t_at_max), .at_zero_o(t_at_zero)
  );

  hour_step_ctrl #(.DIGW(DIGW), .LAST_T(LAST_T), .LAST_U(LAST_U)) u_ctrl (
    .rst_i(rst_i), .en_i(en_i), .down_i(down_i),
    .tens_i(hour_q.tens), .units_i(hour_q.units),
    .u_at_max_i(u_at_max), .u_at_zero_i(u_at_zero), .t_at_zero_i(t_at_zero),
    .u_inc_o(u_inc), .u_dec_o(u_dec), .t_inc_o(t_inc), .t_dec_o(t_dec),
    .ld_o(ld), .ld_t_o(ld_t), .ld_u_o(ld_u),
    .at_last_o(at_last), .at_first_o(at_first), .tc_o(tc_o)
  );

  hour_code_map #(.HOURS(HOURS)) u_map (
    .mode12_i(mode12_i), .hour_i(hour_q), .shown_o(shown), .pm_o(pm_o)
  );

  assign tens_o  = shown.tens;
  assign units_o = shown.units;

  AST_RESET_ZERO: assert property (@(posedge clk_i)
    rst_i |=> (hour_q == '0)); // R1

  AST_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> $stable(hour_q)); // R2

  AST_UP_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !down_i && at_last) |=> (hour_q == '0)); // R4

  AST_DN_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && down_i && at_first) |=> (hour_to_bin(hour_q) == 7'(LAST))); // R6

  AST_IN_DAY: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> (hour_to_bin(hour_q) <= 7'(LAST))); // R3

  AST_TC_AT_EDGE: assert property (@(posedge clk_i) disable iff (rst_i)
    tc_o |-> (at_last || at_first)); // R7

  AST_PM_ONLY_12H: assert property (@(posedge clk_i) disable iff (rst_i)
    pm_o |-> mode12_i); // R8

  AST_TENS_12H: assert property (@(posedge clk_i) disable iff (rst_i)
    mode12_i |-> (tens_o <= 4'd1) && !(tens_o == 4'd0 && units_o == 4'd0)); // R9

  logic unused_ok;
  assign unused_ok = t_at_max;
endmodule

// File: tb/hour_ring_bcd_bench.sv
module hour_ring_bcd_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0, dn = 1'b0, m12 = 1'b0;
  logic [3:0] tens, units;
  logic pm, tc;

  always #(PERIOD/2) clk = ~clk;

  hour_ring_bcd u_hour_ring_bcd (
    .clk_i(clk), .rst_i(rst), .en_i(en), .down_i(dn), .mode12_i(m12),
    .tens_o(tens), .units_o(units), .pm_o(pm), .tc_o(tc)
  );

  typedef struct {
    logic [3:0] t;
    logic [3:0] u;
    logic       pm;
    logic       tc;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int h = 0;   // model of the stored hour
  bit done = 0;

  // driver: apply inputs for one cycle, queue what the outputs must show
  task automatic drive(input logic r, input logic e, input logic d,
                       input logic m, input string tag);
    exp_t x;
    int disp;
    @(negedge clk);
    rst = r; en = e; dn = d; m12 = m;
    if (m) begin
      disp = (h == 0) ? 12 : ((h > 12) ? h - 12 : h);
      x.pm = (h >= 12);
    end else begin
      disp = h;
      x.pm = 1'b0;
    end
    x.t   = 4'(disp / 10);
    x.u   = 4'(disp % 10);
    x.tc  = !r && e && ((!d && h == 23) || (d && h == 0));
    x.tag = tag;
    q.push_back(x);
    if (r)      h = 0;
    else if (e) h = d ? ((h == 0) ? 23 : h - 1) : ((h == 23) ? 0 : h + 1);
  endtask

  // monitor: pop and compare away from the clock edge
  initial begin
    exp_t x;
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      if (q.size() > 0) begin
        x = q.pop_front();
        checks++;
        if (tens !== x.t || units !== x.u || pm !== x.pm || tc !== x.tc) begin
          errors++;
          $display("FAIL %s: got %0d%0d pm=%0b tc=%0b exp %0d%0d pm=%0b tc=%0b",
                   x.tag, tens, units, pm, tc, x.t, x.u, x.pm, x.tc);
        end
      end
    end
  end

  initial begin
    #(PERIOD*100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run exp finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // settle: reset with no checks
    repeat (2) @(negedge clk);
    h = 0;
    drive(1, 0, 0, 0, "R1_reset_state");
    // R3 / R4 / R7: full day upward, crosses 9->10, 19->20, 23->00
    for (int i = 0; i < 26; i++) drive(0, 1, 0, 0, "R3_R4_R7_up");
    // R2: hold with enable low, both directions
    for (int i = 0; i < 3; i++) drive(0, 0, i[0], 0, "R2_hold");
    // R5 / R6 / R7: full day downward, crosses 00->23, 20->19, 10->09
    for (int i = 0; i < 27; i++) drive(0, 1, 1, 0, "R5_R6_R7_down");
    // R8: 24-hour code at a few held values
    drive(0, 0, 0, 0, "R8_code24");
    // R9: all hours in 12-hour code, counting up
    while (h != 0) drive(0, 1, 1, 0, "R6_to_zero");
    for (int i = 0; i < 25; i++) drive(0, 1, 0, 1, "R9_code12");
    // R10: toggle mode every cycle while counting, sequence must not care
    for (int i = 0; i < 30; i++) drive(0, 1, 0, i[0], "R10_mode_free");
    // bring to 23 counting up, then switch mode on in the wrap cycle
    while (h != 23) drive(0, 1, 0, 0, "R3_to_23");
    drive(0, 1, 0, 1, "R7_R9_wrap_in_12h");
    drive(0, 0, 0, 1, "R4_R9_after_wrap");
    // R1: reset while enabled at the boundary
    while (h != 23) drive(0, 1, 1, 0, "R5_to_23");
    drive(1, 1, 0, 0, "R1_R7_reset_beats_step");
    drive(0, 0, 0, 0, "R1_after_reset");
    drive(1, 1, 1, 1, "R1_reset_down_12h");
    drive(0, 1, 1, 0, "R6_R7_after_reset");
    drive(0, 0, 0, 0, "R6_landed");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule